// File: doc/BRIEF.md
# Line and Frame Enable Generator

This block produces the two timing gates that a detector readout needs: a per-line enable pulse and a per-frame enable window. The line gate is timed in ADC clock strobes counted from the most recent line-start event. The frame gate is timed in quad-done strobes counted from the most recent frame reset.

A host programs three 16-bit configuration words over a simple single-cycle register bus and can read them back. The line configuration word packs two byte counts. The upper byte is the count at which the line gate closes, and the lower byte is the count at which it opens. The frame window has one word for its opening count and one for its closing count.

A read-only status word shows both gates and a sticky flag that records a completed frame window. Reading the status word clears that flag. Both gates and the read data come from registers, so they change only on a rising clock edge.

Top module: `line_frame_gen`

## Requirements
- R1: While and after synchronous reset, line_enable, frame_enable and rd_data are 0, and all configuration words read back as 0x0000.
- R2: Writes at register index 11 (line configuration), 14 (frame open count) and 17 (frame close count) are stored and read back. A read returns data on rd_data one clock after rd_en. Writes to index 8 (status) or to any other index are ignored, and reads of unmapped indices return 0x0000.
- R3: line_enable stays 0 until the first line_start. Each line_start resets the ADC strobe count to 0. line_enable rises on the clock edge that brings the count up to the lower byte of the line configuration, or on the line_start edge itself when that byte is 0.
- R4: line_enable falls on the clock edge that brings the ADC strobe count up to the upper byte of the line configuration. With 0x4202 the gate is high from count 2 up to count 65 and falls at count 66.
- R5: If the upper byte is less than or equal to the lower byte, line_enable never rises.
- R6: A line_start in the middle of a line restarts the count at 0. An adc_tick in the same cycle as line_start is not counted.
- R7: After a frame reset the quad-done count is 0. frame_enable rises on the edge where the count reaches the frame open count. With an open count of 1, it rises on the first quad_done.
- R8: frame_enable falls on the edge where the quad-done count reaches the frame close count (with 0x43FF, on pulse 17407). A frame_rst at any time restarts the count at 0.
- R9: If the frame close count is less than or equal to the open count, frame_enable never rises.
- R10: The status word at index 8 carries line_enable in bit 0, frame_enable in bit 1, and in bit 2 a sticky flag. The flag is set when a quad_done closes an open frame window and cleared by a status read. If a set and a clear fall in the same cycle, the set wins.
- R11: The ADC strobe count saturates at 255 and the quad-done count at 65535, so neither wraps and reopens a gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 5 | Register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid the cycle after rd_en |
| adc_tick | input | 1 | One-cycle ADC clock strobe |
| line_start | input | 1 | One-cycle line-start event |
| quad_done | input | 1 | One-cycle quad-done strobe |
| frame_rst | input | 1 | One-cycle frame reset |
| line_enable | output | 1 | Line enable gate |
| frame_enable | output | 1 | Frame enable window |

## Verification
The assertions assume the strobes are clean one-cycle-per-event signals with no unknown values. The gate-stability properties assume the configuration changes only through a bus write, so they are gated off in any cycle that carries wr_en. The bench follows these assumptions. It changes the configuration only between scenarios, never while a gate is being measured. It drives every strobe on the falling edge, so each counted event occupies whole clock cycles. The long frame window runs the stated 17407-pulse close count in full, with quad_done held high on every cycle.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 5;
  localparam int HALF_W  = DATA_W / 2;

  localparam logic [IDX_W-1:0] IDX_STATUS = 5'd8;
  localparam logic [IDX_W-1:0] IDX_LINE   = 5'd11;
  localparam logic [IDX_W-1:0] IDX_FOPEN  = 5'd14;
  localparam logic [IDX_W-1:0] IDX_FCLOSE = 5'd17;

  localparam int ST_LINE  = 0;
  localparam int ST_FRAME = 1;
  localparam int ST_DONE  = 2;

  typedef struct packed {
    logic [HALF_W-1:0] close_cnt;
    logic [HALF_W-1:0] open_cnt;
  } line_cfg_t;
endpackage

// File: rtl/lfg_regs.sv
module lfg_regs
  import lfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_en,
  input  logic              frame_en,
  input  logic              done_evt,
  output logic [DATA_W-1:0] rd_data,
  output line_cfg_t         line_cfg,
  output logic [DATA_W-1:0] fopen,
  output logic [DATA_W-1:0] fclose
);
  logic              sticky_q;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_mux;
  logic              status_rd;

  assign status_rd = rd_en && (reg_idx == IDX_STATUS);

  always_comb begin
    status_w = '0;
    status_w[ST_LINE]  = line_en;
    status_w[ST_FRAME] = frame_en;
    status_w[ST_DONE]  = sticky_q;
  end

  always_comb begin
    case (reg_idx)
      IDX_STATUS: rd_mux = status_w;
      IDX_LINE:   rd_mux = line_cfg;
      IDX_FOPEN:  rd_mux = fopen;
      IDX_FCLOSE: rd_mux = fclose;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cfg <= '0;
      fopen    <= '0;
      fclose   <= '0;
      rd_data  <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_idx)
          IDX_LINE:   line_cfg <= wr_data;
          IDX_FOPEN:  fopen    <= wr_data;
          IDX_FCLOSE: fclose   <= wr_data;
          default: ;
        endcase
      end
      if (rd_en) rd_data <= rd_mux;
      if (done_evt)       sticky_q <= 1'b1;
      else if (status_rd) sticky_q <= 1'b0;
    end
  end

  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> sticky_q);
  // R10
  sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && !done_evt) |=> !sticky_q);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(line_cfg) && $stable(fopen) && $stable(fclose)));
endmodule

// File: rtl/lfg_line.sv
module lfg_line #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] open_cnt,
  input  logic [CNT_W-1:0] close_cnt,
  output logic             line_en
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             act_q, act_n;
  logic             en_n;

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (restart) begin
      cnt_n = '0;
      act_n = 1'b1;
    end else if (tick && act_q && (cnt_q != CNT_MAX)) begin
      cnt_n = cnt_q + 1'b1;
    end
    en_n = act_n && (cnt_n >= open_cnt) && (cnt_n < close_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= 1'b0;
      line_en <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      act_q   <= act_n;
      line_en <= en_n;
    end
  end

  // R5
  line_inverted_chk: assert property (@(posedge clk) disable iff (rst)
    (close_cnt <= open_cnt) |=> !line_en);
  // R3
  line_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (line_en == ($past(open_cnt) == '0 && $past(close_cnt) != '0)));
  // R11
  line_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/lfg_frame.sv
module lfg_frame #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             quad,
  input  logic             restart,
  input  logic [CNT_W-1:0] open_cnt,
  input  logic [CNT_W-1:0] close_cnt,
  output logic             frame_en,
  output logic             done_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             en_n;

  always_comb begin
    cnt_n = cnt_q;
    if (restart)
      cnt_n = '0;
    else if (quad && (cnt_q != CNT_MAX))
      cnt_n = cnt_q + 1'b1;
    en_n     = (cnt_n >= open_cnt) && (cnt_n < close_cnt);
    done_evt = quad && !restart && frame_en && !en_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      frame_en <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      frame_en <= en_n;
    end
  end

  // R9
  frame_inverted_chk: assert property (@(posedge clk) disable iff (rst)
    (close_cnt <= open_cnt) |=> !frame_en);
  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (frame_en == ($past(open_cnt) == '0 && $past(close_cnt) != '0)));
  // R11
  frame_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/line_frame_gen.sv
module line_frame_gen
  import lfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              adc_tick,
  input  logic              line_start,
  input  logic              quad_done,
  input  logic              frame_rst,
  output logic              line_enable,
  output logic              frame_enable
);
  line_cfg_t         line_cfg;
  logic [DATA_W-1:0] fopen, fclose;
  logic              done_evt;

  lfg_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .reg_idx  (reg_idx),
    .wr_data  (wr_data),
    .line_en  (line_enable),
    .frame_en (frame_enable),
    .done_evt (done_evt),
    .rd_data  (rd_data),
    .line_cfg (line_cfg),
    .fopen    (fopen),
    .fclose   (fclose)
  );

  lfg_line #(.CNT_W(HALF_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .tick      (adc_tick),
    .restart   (line_start),
    .open_cnt  (line_cfg.open_cnt),
    .close_cnt (line_cfg.close_cnt),
    .line_en   (line_enable)
  );

  lfg_frame #(.CNT_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .quad      (quad_done),
    .restart   (frame_rst),
    .open_cnt  (fopen),
    .close_cnt (fclose),
    .frame_en  (frame_enable),
    .done_evt  (done_evt)
  );

  // R3
  line_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !line_start && !adc_tick) |=> $stable(line_enable));
  // R7
  frame_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !frame_rst && !quad_done) |=> $stable(frame_enable));
endmodule

// File: tb/line_frame_gen_bench.sv
module line_frame_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        adc_tick = 1'b0, line_start = 1'b0, quad_done = 1'b0, frame_rst = 1'b0;
  logic        line_enable, frame_enable;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_frame_gen u_line_frame_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .rd_data(rd_data), .adc_tick(adc_tick),
    .line_start(line_start), .quad_done(quad_done), .frame_rst(frame_rst),
    .line_enable(line_enable), .frame_enable(frame_enable)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [15:0] d);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] idx, output logic [15:0] d);
    rd_en = 1'b1; reg_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic ticks(int n);
    adc_tick = 1'b1;
    repeat (n) @(negedge clk);
    adc_tick = 1'b0;
  endtask

  task automatic quads(int n);
    quad_done = 1'b1;
    repeat (n) @(negedge clk);
    quad_done = 1'b0;
  endtask

  task automatic pulse_line();
    line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask

  task automatic pulse_frame();
    frame_rst = 1'b1; @(negedge clk); frame_rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 line_enable", {15'b0, line_enable}, 16'h0);
    chk("R1 frame_enable", {15'b0, frame_enable}, 16'h0);
    chk("R1 rd_data", rd_data, 16'h0);
    rd(5'd11, d); chk("R1 line cfg", d, 16'h0);
    rd(5'd17, d); chk("R1 close cfg", d, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(5'd11, 16'h1234); wr(5'd14, 16'hBEEF); wr(5'd17, 16'h0F0F);
    rd(5'd11, d); chk("R2 idx11", d, 16'h1234);
    rd(5'd14, d); chk("R2 idx14", d, 16'hBEEF);
    rd(5'd17, d); chk("R2 idx17", d, 16'h0F0F);
    wr(5'd8, 16'hFFFF);
    rd(5'd8, d); chk("R2 status write ignored", d, 16'h0000);
    wr(5'd3, 16'hA5A5);
    rd(5'd3, d); chk("R2 unmapped", d, 16'h0000);
    wr(5'd11, 16'h0000); wr(5'd14, 16'h0000); wr(5'd17, 16'h0000);
  endtask

  task automatic t_line_nominal();
    wr(5'd11, 16'h4202);
    ticks(5); chk("R3 no gate before line start", {15'b0, line_enable}, 16'h0);
    pulse_line(); chk("R3 count 0", {15'b0, line_enable}, 16'h0);
    ticks(1);  chk("R3 count 1", {15'b0, line_enable}, 16'h0);
    ticks(1);  chk("R3 count 2 opens", {15'b0, line_enable}, 16'h1);
    ticks(63); chk("R4 count 65 still open", {15'b0, line_enable}, 16'h1);
    ticks(1);  chk("R4 count 66 closes", {15'b0, line_enable}, 16'h0);
    ticks(20); chk("R4 stays closed", {15'b0, line_enable}, 16'h0);
  endtask

  task automatic t_line_inverted();
    int hi;
    wr(5'd11, 16'h0505);
    pulse_line(); hi = 0;
    for (int i = 0; i < 20; i++) begin ticks(1); if (line_enable) hi++; end
    chk("R5 equal counts never open", 16'(hi), 16'h0);
    wr(5'd11, 16'h0308);
    pulse_line(); hi = 0;
    for (int i = 0; i < 20; i++) begin ticks(1); if (line_enable) hi++; end
    chk("R5 close below open never opens", 16'(hi), 16'h0);
  endtask

  task automatic t_line_restart();
    wr(5'd11, 16'h0A01);
    pulse_line(); ticks(5);
    chk("R6 open mid line", {15'b0, line_enable}, 16'h1);
    line_start = 1'b1; adc_tick = 1'b1; @(negedge clk);
    line_start = 1'b0; adc_tick = 1'b0;
    chk("R6 restart with tick not counted", {15'b0, line_enable}, 16'h0);
    ticks(1); chk("R6 reopen at 1", {15'b0, line_enable}, 16'h1);
  endtask

  task automatic t_line_sat();
    wr(5'd11, 16'hFF00);
    pulse_line(); chk("R3 open at count 0", {15'b0, line_enable}, 16'h1);
    ticks(254); chk("R11 open at 254", {15'b0, line_enable}, 16'h1);
    ticks(1);   chk("R11 closes at 255", {15'b0, line_enable}, 16'h0);
    ticks(10);  chk("R11 no wrap", {15'b0, line_enable}, 16'h0);
    wr(5'd11, 16'h0000);
  endtask

  task automatic t_frame_small();
    logic [15:0] d;
    wr(5'd14, 16'd3); wr(5'd17, 16'd5);
    pulse_frame(); chk("R7 closed after reset", {15'b0, frame_enable}, 16'h0);
    quads(2); chk("R7 count 2", {15'b0, frame_enable}, 16'h0);
    quads(1); chk("R7 opens at 3", {15'b0, frame_enable}, 16'h1);
    rd(5'd8, d); chk("R10 status frame bit", d, 16'h0002);
    quads(1); chk("R8 open at 4", {15'b0, frame_enable}, 16'h1);
    pulse_frame(); chk("R8 reset closes", {15'b0, frame_enable}, 16'h0);
    quads(3); chk("R8 reopens at 3", {15'b0, frame_enable}, 16'h1);
    quads(2); chk("R8 closes at 5", {15'b0, frame_enable}, 16'h0);
    rd(5'd8, d); chk("R10 sticky set", d, 16'h0004);
    rd(5'd8, d); chk("R10 sticky cleared by read", d, 16'h0000);
  endtask

  task automatic t_frame_inverted();
    int hi;
    wr(5'd14, 16'd5); wr(5'd17, 16'd5);
    pulse_frame(); hi = 0;
    for (int i = 0; i < 10; i++) begin quads(1); if (frame_enable) hi++; end
    chk("R9 equal counts never open", 16'(hi), 16'h0);
  endtask

  task automatic t_frame_long();
    logic [15:0] d;
    wr(5'd14, 16'h0001); wr(5'd17, 16'h43FF);
    pulse_frame(); chk("R7 closed at 0", {15'b0, frame_enable}, 16'h0);
    quads(1); chk("R7 opens after first pulse", {15'b0, frame_enable}, 16'h1);
    quads(17405); chk("R8 open at 17406", {15'b0, frame_enable}, 16'h1);
    quads(1); chk("R8 closes at 17407", {15'b0, frame_enable}, 16'h0);
    rd(5'd8, d); chk("R10 sticky after long frame", d, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_regs();
    t_line_nominal();
    t_line_inverted();
    t_line_restart();
    t_line_sat();
    t_frame_small();
    t_frame_inverted();
    t_frame_long();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule